// File: doc/BRIEF.md
# Main Clock Frequency Meter

This block measures how fast a main clock runs by counting its cycles across a gate window. The window is timed by a slow reference clock whose frequency is known. Software first raises the oscillator-stable input. The block then arms on the next rising edge of the slow clock and opens the window on the falling edge that follows. It counts main clock cycles until 16 further falling edges of the slow clock have been seen. At that point it freezes the total and raises a ready flag. Dividing the count by 16 gives the ratio of main to slow clock frequency. Turning that ratio into hertz is left to software.

All logic runs on the main clock. The slow clock is treated as an asynchronous data input and passes through a two-flop synchronizer before its edges are detected. Because of this, the result carries a tolerance of a couple of main clock cycles. The stable input is taken to be synchronous to the main clock.

The read port is a plain status pair, `meas_count` and `meas_ready`, with no handshake. It applies no back-pressure: a reader may sample it on any cycle. The count reads zero until ready is set, and both change on the same edge. Dropping the stable input clears both so that a new measurement can start.

Top module: `mainclk_meter`

## Requirements
- R1: While `osc_stable` is low, no measurement proceeds: `meas_ready` stays 0 and `meas_count` stays 0, however long the slow clock runs.
- R2: After `osc_stable` rises, the gate arms on the next synchronized rising edge of `slow_clk` and counting begins at the falling edge that follows. If `osc_stable` is raised during a low phase of `slow_clk`, `meas_ready` rises about 17 slow periods later, within ±3 main cycles.
- R3: The window closes on the 16th synchronized falling edge of `slow_clk` after counting began. `meas_ready` rises in the cycle after that edge is detected. From then on, `meas_ready` and `meas_count` hold steady for as long as `osc_stable` stays high.
- R4: The frozen count equals the number of main clock cycles in 16 slow clock periods, within ±2 counts.
- R5: The count is `CNT_W` bits wide (16 by default) and saturates at its all-ones value (65535) instead of wrapping.
- R6: A low on `osc_stable` clears `meas_ready` and `meas_count` to 0 at the next main clock edge.
- R7: `meas_count` reads 0 whenever `meas_ready` is 0. The count and the ready flag are loaded on the same edge, so a count that is still changing is never visible.
- R8: While `rst_n` is low, `meas_ready` and `meas_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main | input | 1 | Main clock being measured; every register runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk | input | 1 | Slow reference clock, asynchronous to clk_main |
| osc_stable | input | 1 | High once the main oscillator is stable; low clears the result |
| meas_count | output | 16 | Frozen main cycle count for 16 slow periods, 0 until ready |
| meas_ready | output | 1 | Measurement complete and count valid |

## Verification
The hardest situation to reach from the ports is saturation. It needs more than 65535 main cycles inside one window. The stimulus gets there by slowing the reference so that one slow period spans 4100 main cycles. The arming rule is also easy to mask, because the stable input can arrive near a slow edge and the synchronizer delay then blurs which edge arms the gate. The stimulus therefore raises the stable input on a slow falling edge. The expected latency then becomes a single value: 17 slow periods.

// File: rtl/mcm_pkg.sv
package mcm_pkg;
  typedef enum logic [2:0] {
    GATE_IDLE,
    GATE_ARM,
    GATE_OPEN,
    GATE_RUN,
    GATE_DONE
  } gate_state_e;
endpackage

// File: rtl/mcm_edge_sync.sv
module mcm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_p,
  output logic fall_p
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_p = sync_q[STAGES-1] & ~last_q;
  assign fall_p = ~sync_q[STAGES-1] & last_q;
endmodule

// File: rtl/mcm_sat_counter.sv
module mcm_sat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] cnt_next
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt_q;

  assign cnt_next = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (en)  cnt_q <= cnt_next;
  end
endmodule

// File: rtl/mcm_gate_ctrl.sv
module mcm_gate_ctrl
  import mcm_pkg::*;
#(
  parameter int WIN_PERIODS = 16,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stable,
  input  logic             rise_p,
  input  logic             fall_p,
  input  logic [CNT_W-1:0] cnt_next,
  output logic             cnt_en,
  output logic             cnt_clr,
  output logic             ready,
  output logic [CNT_W-1:0] result
);
  localparam int FW = $clog2(WIN_PERIODS + 1);
  localparam logic [FW-1:0] LAST_FALL = FW'(WIN_PERIODS - 1);

  gate_state_e      state_q;
  logic [FW-1:0]    falls_q;

  assign cnt_en  = (state_q == GATE_RUN);
  assign cnt_clr = (state_q != GATE_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GATE_IDLE;
      falls_q <= '0;
      ready   <= 1'b0;
      result  <= '0;
    end else if (!stable) begin
      state_q <= GATE_IDLE;
      falls_q <= '0;
      ready   <= 1'b0;
      result  <= '0;
    end else begin
      case (state_q)
        GATE_IDLE: state_q <= GATE_ARM;
        GATE_ARM:  if (rise_p) state_q <= GATE_OPEN;
        GATE_OPEN: if (fall_p) begin
          state_q <= GATE_RUN;
          falls_q <= '0;
        end
        GATE_RUN: if (fall_p) begin
          if (falls_q == LAST_FALL) begin
            state_q <= GATE_DONE;
            ready   <= 1'b1;
            result  <= cnt_next;
          end else begin
            falls_q <= falls_q + 1'b1;
          end
        end
        default: state_q <= GATE_DONE;
      endcase
    end
  end
endmodule

// File: rtl/mainclk_meter.sv
module mainclk_meter #(
  parameter int CNT_W       = 16,
  parameter int WIN_PERIODS = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_main,
  input  logic             rst_n,
  input  logic             slow_clk,
  input  logic             osc_stable,
  output logic [CNT_W-1:0] meas_count,
  output logic             meas_ready
);
  logic             slow_rise;
  logic             slow_fall;
  logic             cnt_en;
  logic             cnt_clr;
  logic [CNT_W-1:0] cnt_next;

  mcm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk_main),
    .rst_n    (rst_n),
    .async_in (slow_clk),
    .rise_p   (slow_rise),
    .fall_p   (slow_fall)
  );

  mcm_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk_main),
    .rst_n    (rst_n),
    .clr      (cnt_clr),
    .en       (cnt_en),
    .cnt_next (cnt_next)
  );

  mcm_gate_ctrl #(.WIN_PERIODS(WIN_PERIODS), .CNT_W(CNT_W)) u_gate (
    .clk      (clk_main),
    .rst_n    (rst_n),
    .stable   (osc_stable),
    .rise_p   (slow_rise),
    .fall_p   (slow_fall),
    .cnt_next (cnt_next),
    .cnt_en   (cnt_en),
    .cnt_clr  (cnt_clr),
    .ready    (meas_ready),
    .result   (meas_count)
  );
endmodule

// File: rtl/mcm_checker.sv
module mcm_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             osc_stable,
  input logic             fall_p,
  input logic             meas_ready,
  input logic [CNT_W-1:0] meas_count
);
  // R6
  clear_on_unstable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_stable |=> (!meas_ready && meas_count == '0));

  // R7
  zero_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_ready |-> meas_count == '0);

  // R3
  result_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_ready && osc_stable) |=> (meas_ready && $stable(meas_count)));

  // R3
  close_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(meas_ready) |-> $past(fall_p));

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!meas_ready && meas_count == '0));
endmodule

bind mainclk_meter mcm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk_main),
  .rst_n      (rst_n),
  .osc_stable (osc_stable),
  .fall_p     (slow_fall),
  .meas_ready (meas_ready),
  .meas_count (meas_count)
);

// File: tb/mainclk_meter_bench.sv
`timescale 1ns/1ps
module mainclk_meter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 4;
  localparam int RATIOS [N_VEC] = '{4, 7, 12, 25};

  logic        clk_main = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_clk = 1'b0;
  logic        osc_stable = 1'b0;
  logic [15:0] meas_count;
  logic        meas_ready;
  int          slow_half = 40;
  int          n_chk = 0;
  int          n_fail = 0;
  int          busy_bad = 0;

  mainclk_meter u_mainclk_meter (
    .clk_main   (clk_main),
    .rst_n      (rst_n),
    .slow_clk   (slow_clk),
    .osc_stable (osc_stable),
    .meas_count (meas_count),
    .meas_ready (meas_ready)
  );

  always #(CLK_PERIOD/2) clk_main = ~clk_main;
  always begin
    #(slow_half) slow_clk = ~slow_clk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Waits for ready, counting main cycles; flags a nonzero count seen while busy (R7).
  task automatic wait_ready(input int limit, output int elapsed);
    elapsed = 0;
    while (!meas_ready && elapsed < limit) begin
      @(negedge clk_main);
      elapsed++;
      if (!meas_ready && meas_count != 0) busy_bad++;
    end
  endtask

  task automatic measure(input int ratio, output int got, output int ok);
    int el;
    @(negedge clk_main);
    osc_stable = 1'b0;
    slow_half = ratio * CLK_PERIOD / 2;
    repeat (2 * ratio + 4) @(negedge clk_main);
    osc_stable = 1'b1;
    wait_ready(ratio * 40 + 100, el);
    got = int'(meas_count);
    ok = meas_ready;
  endtask

  initial begin
    repeat (190000) @(posedge clk_main);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int got, ok, el, hold;
    // R8: reset state
    repeat (3) @(negedge clk_main);
    check(meas_ready == 0 && meas_count == 0, "R8", int'(meas_count), 0);
    rst_n = 1'b1;

    // R1: stable low for many slow periods
    repeat (40 * 8) @(negedge clk_main);
    check(meas_ready == 0, "R1 ready", int'(meas_ready), 0);
    check(meas_count == 0, "R1 count", int'(meas_count), 0);

    // R4: table of ratios
    for (int i = 0; i < N_VEC; i++) begin
      measure(RATIOS[i], got, ok);
      check(ok == 1, "R4 ready", ok, 1);
      check(got >= 16 * RATIOS[i] - 2 && got <= 16 * RATIOS[i] + 2, "R4 count", got, 16 * RATIOS[i]);
    end

    // R3: result frozen while stable stays high
    hold = int'(meas_count);
    repeat (25 * 6) @(negedge clk_main);
    check(meas_ready == 1 && int'(meas_count) == hold, "R3 frozen", int'(meas_count), hold);

    // R6: drop stable clears at next edge
    osc_stable = 1'b0;
    @(negedge clk_main);
    check(meas_ready == 0 && meas_count == 0, "R6 clear", int'(meas_count), 0);

    // R2: raise stable at a slow falling edge with ratio 8 -> ready after 17 periods
    slow_half = 40;
    repeat (40) @(negedge clk_main);
    @(negedge slow_clk);
    @(negedge clk_main);
    osc_stable = 1'b1;
    wait_ready(400, el);
    check(el >= 136 - 3 && el <= 136 + 3, "R2 latency", el, 136);
    check(int'(meas_count) >= 126 && int'(meas_count) <= 130, "R4 ratio 8", int'(meas_count), 128);

    // R5: saturation with 4100 main cycles per slow period
    measure(4100, got, ok);
    check(ok == 1 && got == 65535, "R5 saturate", got, 65535);

    // R7: count never visible while busy
    check(busy_bad == 0, "R7 busy count", busy_bad, 0);

    // R8: reset in the middle of a result clears it
    rst_n = 1'b0;
    @(negedge clk_main);
    check(meas_ready == 0 && meas_count == 0, "R8 reset clears", int'(meas_count), 0);
    finish_run();
  end
endmodule